// File: doc/BRIEF.md
# Supply-Loss Write Guard

This block supervises access to a battery-backed static memory. Each clock it may receive a digitized supply reading, an unsigned binary code in millivolts, and it decides whether the memory may be used. Three outputs carry the decision. A write-protect line blocks writes. A bus-isolate line masks every strobe and tells the data path to float its drivers. A source-select line picks the main supply or the backup cell as the memory's feed.

Three thresholds, all parameters in millivolts, set its behaviour. The trip level (default 4370) starts protection when the supply sags. The switchover level (default 3000) moves the memory onto the backup cell. The resume level (default 4500) sits above the trip level. Protection is lifted only once the supply is back above the resume level, so a supply hovering between the two levels keeps the memory locked. A level crossing takes effect only after it has held for `FILT_N` consecutive valid readings (default 4). A sticky flag records each trip from full operation until the host clears it. After reset the block is always protected. The first valid reading then selects either the main supply or the backup cell.

The host strobes (chip select, write, output enable) pass through the block. They reach the memory only while operation is fully allowed.

Top module: `pwr_guard`

## Requirements
- R1: While reset is applied, and after it until the first valid reading, `wr_protect` and `bus_iso` are 1 and `use_backup` and `fail_flag` are 0.
- R2: The first valid reading after reset is acted on at once, with no filtering. If it is below SWITCH_MV, `use_backup` is 1 from the next clock. Otherwise the block stays protected on the main supply.
- R3: In full operation, FILT_N consecutive valid readings below TRIP_MV set `wr_protect` and `bus_iso`. This holds even when a reading is also below SWITCH_MV: from full operation the block goes first to protected on the main supply, never straight to backup.
- R4: While protected on the main supply, FILT_N consecutive valid readings below SWITCH_MV select the backup cell. On the backup cell, FILT_N consecutive valid readings above SWITCH_MV select the main supply again, and protection stays on. A reading equal to SWITCH_MV moves neither way. `use_backup` is never 1 while `wr_protect` is 0.
- R5: While protected, protection is lifted only after FILT_N consecutive valid readings strictly above RESUME_MV. Readings from TRIP_MV up to and including RESUME_MV keep protection on.
- R6: A valid reading that does not continue the current run of crossings restarts the count. Cycles with `smp_valid` low neither count nor break a run, and they never change any output.
- R7: While `bus_iso` is 1, `mem_ce`, `mem_we` and `mem_oe` are 0 whatever the requests. In full operation each one equals its request input (`req_ce`, `req_we`, `req_oe`).
- R8: `fail_flag` becomes 1 on the clock at which a trip from full operation takes effect. It holds until `fail_clr` is sampled high. A trip in the same cycle as `fail_clr` leaves the flag at 1.
- R9: Every state change takes effect on the clock edge that samples the qualifying reading. An access in progress is cut off from that edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid | input | 1 | A new supply reading is present this cycle |
| smp_mv | input | SMP_W | Supply reading in millivolts, unsigned |
| req_ce | input | 1 | Host chip-select request, active high |
| req_we | input | 1 | Host write request, active high |
| req_oe | input | 1 | Host output-enable request, active high |
| fail_clr | input | 1 | Clears the supply-fail flag |
| wr_protect | output | 1 | Writes blocked |
| bus_iso | output | 1 | Strobes masked, data drivers to high impedance |
| use_backup | output | 1 | 1 selects the backup cell, 0 the main supply |
| mem_ce | output | 1 | Gated chip select to the memory |
| mem_we | output | 1 | Gated write strobe to the memory |
| mem_oe | output | 1 | Gated output enable to the memory |
| fail_flag | output | 1 | Sticky record of a trip from full operation |

## Verification
A wrong state register or a corrupt run counter shows up at the ports as a protection or source change at the wrong reading. This is caught on the clock right after the expected edge, because the bench's model predicts every output in every cycle. Each scenario places runs of N-1 qualifying readings before a breaking reading. A counter that runs too early, too late or without restarting therefore shows up within one reading. Readings exactly at the switchover and resume levels expose an off-by-one in any comparison. Requests held active across a trip show, on the very next clock, whether the gating lags the state.

// File: rtl/pg_pkg.sv
package pg_pkg;

  typedef enum logic [1:0] {
    PG_NORMAL = 2'd0,
    PG_PROT   = 2'd1,
    PG_BACKUP = 2'd2
  } pg_state_e;

  function automatic logic pg_locked(input pg_state_e s);
    return (s != PG_NORMAL);
  endfunction

  function automatic logic pg_on_cell(input pg_state_e s);
    return (s == PG_BACKUP);
  endfunction

endpackage

// File: rtl/pg_filter.sv
module pg_filter
  import pg_pkg::*;
#(
  parameter int SMP_W     = 13,
  parameter int TRIP_MV   = 4370,
  parameter int SWITCH_MV = 3000,
  parameter int RESUME_MV = 4500,
  parameter int FILT_N    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_mv,
  input  pg_state_e        cur_st,
  output logic             commit,
  output pg_state_e        commit_st
);

  localparam int CNT_W = $clog2(FILT_N + 1);
  localparam logic [SMP_W-1:0] TRIP_C   = SMP_W'(TRIP_MV);
  localparam logic [SMP_W-1:0] SWITCH_C = SMP_W'(SWITCH_MV);
  localparam logic [SMP_W-1:0] RESUME_C = SMP_W'(RESUME_MV);
  localparam logic [CNT_W:0]   LAST_C   = (CNT_W + 1)'(FILT_N);
  localparam logic [CNT_W:0]   ONE_C    = (CNT_W + 1)'(1);

  pg_state_e        want;
  pg_state_e        want_q, want_d;
  logic [CNT_W-1:0] run_q, run_d;
  logic [CNT_W:0]   run_inc;
  logic             run_en, hit, extend;

  // target state implied by this reading alone
  always_comb begin
    want = cur_st;
    case (cur_st)
      PG_NORMAL: if (smp_mv < TRIP_C) want = PG_PROT;
      PG_PROT: begin
        if (smp_mv < SWITCH_C)      want = PG_BACKUP;
        else if (smp_mv > RESUME_C) want = PG_NORMAL;
      end
      PG_BACKUP: if (smp_mv > SWITCH_C) want = PG_PROT;
      default:   want = PG_PROT;
    endcase
  end

  always_comb begin
    run_en    = smp_valid && !hold;
    hit       = run_en && (want != cur_st);
    extend    = hit && (want == want_q) && (run_q != '0);
    run_inc   = extend ? ({1'b0, run_q} + ONE_C) : ONE_C;
    commit    = hit && (run_inc == LAST_C);
    commit_st = want;
    run_d     = run_q;
    want_d    = want_q;
    if (!hit || commit) begin
      run_d = '0;
    end else begin
      run_d  = run_inc[CNT_W-1:0];
      want_d = want;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      want_q <= PG_PROT;
    end else if (run_en) begin
      run_q  <= run_d;
      want_q <= want_d;
    end
  end

endmodule

// File: rtl/pg_fsm.sv
module pg_fsm
  import pg_pkg::*;
#(
  parameter int SMP_W     = 13,
  parameter int SWITCH_MV = 3000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_mv,
  input  logic             commit,
  input  pg_state_e        commit_st,
  input  logic             fail_clr,
  output pg_state_e        st_q,
  output logic             first_q,
  output logic             flag_q
);

  localparam logic [SMP_W-1:0] SWITCH_C = SMP_W'(SWITCH_MV);

  pg_state_e st_d;
  logic      first_d, flag_d, trip;

  always_comb begin
    st_d    = st_q;
    first_d = first_q;
    trip    = 1'b0;
    if (first_q) begin
      if (smp_valid) begin
        first_d = 1'b0;
        st_d    = (smp_mv < SWITCH_C) ? PG_BACKUP : PG_PROT;
      end
    end else if (commit) begin
      st_d = commit_st;
      trip = (st_q == PG_NORMAL);
    end
    if (trip)          flag_d = 1'b1;
    else if (fail_clr) flag_d = 1'b0;
    else               flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= PG_PROT;
      first_q <= 1'b1;
      flag_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
      flag_q  <= flag_d;
    end
  end

endmodule

// File: rtl/pg_gate.sv
module pg_gate
  import pg_pkg::*;
(
  input  pg_state_e st,
  input  logic      req_ce,
  input  logic      req_we,
  input  logic      req_oe,
  output logic      wr_protect,
  output logic      bus_iso,
  output logic      use_backup,
  output logic      mem_ce,
  output logic      mem_we,
  output logic      mem_oe
);

  always_comb begin
    wr_protect = pg_locked(st);
    bus_iso    = pg_locked(st);
    use_backup = pg_on_cell(st);
    mem_ce     = req_ce && !bus_iso;
    mem_we     = req_we && !bus_iso && !wr_protect;
    mem_oe     = req_oe && !bus_iso;
  end

endmodule

// File: rtl/pwr_guard.sv
module pwr_guard
  import pg_pkg::*;
#(
  parameter int SMP_W     = 13,
  parameter int TRIP_MV   = 4370,
  parameter int SWITCH_MV = 3000,
  parameter int RESUME_MV = 4500,
  parameter int FILT_N    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_mv,
  input  logic             req_ce,
  input  logic             req_we,
  input  logic             req_oe,
  input  logic             fail_clr,
  output logic             wr_protect,
  output logic             bus_iso,
  output logic             use_backup,
  output logic             mem_ce,
  output logic             mem_we,
  output logic             mem_oe,
  output logic             fail_flag
);

  logic      rst_meta, rst_sync_n;
  logic      first, commit;
  pg_state_e st, commit_st;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  pg_filter #(
    .SMP_W(SMP_W), .TRIP_MV(TRIP_MV), .SWITCH_MV(SWITCH_MV),
    .RESUME_MV(RESUME_MV), .FILT_N(FILT_N)
  ) u_filt (
    .clk(clk), .rst_n(rst_sync_n), .hold(first),
    .smp_valid(smp_valid), .smp_mv(smp_mv), .cur_st(st),
    .commit(commit), .commit_st(commit_st)
  );

  pg_fsm #(.SMP_W(SMP_W), .SWITCH_MV(SWITCH_MV)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .commit(commit), .commit_st(commit_st), .fail_clr(fail_clr),
    .st_q(st), .first_q(first), .flag_q(fail_flag)
  );

  pg_gate u_gate (
    .st(st), .req_ce(req_ce), .req_we(req_we), .req_oe(req_oe),
    .wr_protect(wr_protect), .bus_iso(bus_iso), .use_backup(use_backup),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_oe(mem_oe)
  );

endmodule

// File: rtl/pg_chk.sv
module pg_chk #(
  parameter int SMP_W     = 13,
  parameter int TRIP_MV   = 4370,
  parameter int RESUME_MV = 4500
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid,
  input logic [SMP_W-1:0] smp_mv,
  input logic             fail_clr,
  input logic             wr_protect,
  input logic             bus_iso,
  input logic             use_backup,
  input logic             mem_ce,
  input logic             mem_we,
  input logic             mem_oe,
  input logic             fail_flag
);

  p_iso_masks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_iso |-> (!mem_ce && !mem_we && !mem_oe));

  p_cell_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    use_backup |-> wr_protect);

  p_cell_not_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    use_backup |=> wr_protect);

  p_trip_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_protect) |-> ($past(smp_valid) && ($past(smp_mv) < SMP_W'(TRIP_MV))));

  p_resume_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_protect) |-> ($past(smp_valid) && ($past(smp_mv) > SMP_W'(RESUME_MV))));

  p_trip_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_protect) |-> fail_flag);

  p_flag_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_flag && !fail_clr) |=> fail_flag);

  p_idle_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable({wr_protect, use_backup}));

endmodule

bind pwr_guard pg_chk #(
  .SMP_W(SMP_W), .TRIP_MV(TRIP_MV), .RESUME_MV(RESUME_MV)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
  .fail_clr(fail_clr), .wr_protect(wr_protect), .bus_iso(bus_iso),
  .use_backup(use_backup), .mem_ce(mem_ce), .mem_we(mem_we),
  .mem_oe(mem_oe), .fail_flag(fail_flag)
);

// File: tb/sim_pwr_guard.sv
`timescale 1ns/1ps
module sim_pwr_guard;

  localparam int W = 13;

  logic clk, rst_n, smp_valid, req_ce, req_we, req_oe, fail_clr;
  logic [W-1:0] smp_mv;
  logic wr_protect, bus_iso, use_backup, mem_ce, mem_we, mem_oe, fail_flag;

  int checks = 0, failures = 0;
  bit done = 0;

  // behavioural model state: 0 full operation, 1 protected on main, 2 on cell
  int m_st, m_want, m_run;
  bit m_first, m_flag;

  pwr_guard u0 (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_mv(smp_mv),
    .req_ce(req_ce), .req_we(req_we), .req_oe(req_oe), .fail_clr(fail_clr),
    .wr_protect(wr_protect), .bus_iso(bus_iso), .use_backup(use_backup),
    .mem_ce(mem_ce), .mem_we(mem_we), .mem_oe(mem_oe), .fail_flag(fail_flag)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 1; m_first = 1; m_flag = 0; m_run = 0; m_want = 1;
    end else begin
      bit trip;
      trip = 0;
      if (smp_valid) begin
        int mv, tgt;
        mv = smp_mv;
        if (m_first) begin
          m_first = 0;
          m_st = (mv < 3000) ? 2 : 1;
        end else begin
          if (m_st == 0)      tgt = (mv < 4370) ? 1 : 0;
          else if (m_st == 1) tgt = (mv < 3000) ? 2 : ((mv > 4500) ? 0 : 1);
          else                tgt = (mv > 3000) ? 1 : 2;
          if (tgt == m_st) m_run = 0;
          else if (tgt == m_want && m_run > 0) m_run++;
          else begin m_run = 1; m_want = tgt; end
          if (m_run == 4) begin
            trip = (m_st == 0);
            m_st = tgt;
            m_run = 0;
          end
        end
      end
      if (trip) m_flag = 1;
      else if (fail_clr) m_flag = 0;
    end
  end

  task automatic cmp(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit locked;
    locked = (m_st != 0);
    cmp("R5", "wr_protect", wr_protect, locked);
    cmp("R7", "bus_iso", bus_iso, locked);
    cmp("R4", "use_backup", use_backup, m_st == 2);
    cmp("R7", "mem_ce", mem_ce, req_ce && !locked);
    cmp("R7", "mem_we", mem_we, req_we && !locked);
    cmp("R7", "mem_oe", mem_oe, req_oe && !locked);
    cmp("R8", "fail_flag", fail_flag, m_flag);
  endtask

  task automatic drive(bit v, int mv, bit ce, bit we, bit oe, bit clr);
    @(negedge clk);
    smp_valid = v; smp_mv = W'(mv);
    req_ce = ce; req_we = we; req_oe = oe; fail_clr = clr;
    #1 compare_all();
  endtask

  task automatic feed(int n, int mv);
    for (int i = 0; i < n; i++) drive(1, mv, 0, 0, 0, 0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
  endtask

  // literal expectations, independent of the model
  task automatic expect_out(string tag, int wp, int bk);
    cmp(tag, "wr_protect(fixed)", wr_protect, wp);
    cmp(tag, "use_backup(fixed)", use_backup, bk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; smp_valid = 0; smp_mv = '0;
    req_ce = 1; req_we = 1; req_oe = 1; fail_clr = 0;
    #1;
    expect_out("R1", 1, 0);
    cmp("R1", "mem_we in reset", mem_we, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    expect_out("R1", 1, 0);
    cmp("R1", "fail_flag after reset", fail_flag, 0);
  endtask

  initial begin
    rst_n = 0; smp_valid = 0; smp_mv = '0;
    req_ce = 0; req_we = 0; req_oe = 0; fail_clr = 0;
    do_reset();
    // R2: low first reading selects the cell at once
    drive(1, 1000, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0, 0);
    expect_out("R2", 1, 1);
    // R4 with an R6 gap inside the run
    feed(2, 3200); idle(2); feed(1, 3200);
    expect_out("R6", 1, 1);
    feed(1, 3200); idle(1);
    expect_out("R4", 1, 0);
    // R5 hysteresis and resume boundary
    feed(6, 4450); feed(5, 4500);
    expect_out("R5", 1, 0);
    // R6 restart on a breaking reading
    feed(3, 4600); feed(1, 4450); feed(3, 4600);
    expect_out("R6", 1, 0);
    feed(1, 4600); idle(1);
    expect_out("R5", 0, 0);
    // R7 pass-through in full operation
    drive(0, 0, 1, 1, 0, 0); drive(0, 0, 1, 0, 1, 0); drive(0, 0, 0, 1, 1, 0);
    // R9 access cut off at the fourth sag reading
    for (int i = 0; i < 3; i++) drive(1, 4300, 1, 1, 0, 0);
    expect_out("R9", 0, 0);
    drive(1, 4300, 1, 1, 0, 0);
    drive(0, 0, 1, 1, 0, 0);
    expect_out("R3", 1, 0);
    cmp("R9", "mem_we after trip", mem_we, 0);
    cmp("R8", "flag after trip", fail_flag, 1);
    idle(3);
    drive(0, 0, 0, 0, 0, 1); idle(1);
    cmp("R8", "flag cleared", fail_flag, 0);
    // R4 switchover and its boundary
    feed(4, 2900); idle(1);
    expect_out("R4", 1, 1);
    feed(5, 3000);
    expect_out("R4", 1, 1);
    feed(4, 3100); feed(4, 4600); idle(1);
    expect_out("R5", 0, 0);
    // R3 deep sag from full operation goes via protected-main
    feed(4, 2000); idle(1);
    expect_out("R3", 1, 0);
    feed(4, 2000); idle(1);
    expect_out("R4", 1, 1);
    // R8 trip and clear in the same cycle
    feed(4, 3500); feed(4, 4700);
    drive(0, 0, 0, 0, 0, 1);
    feed(3, 4000);
    drive(1, 4000, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 0, 0);
    cmp("R8", "set beats clear", fail_flag, 1);
    // R2: high first reading after a new reset stays on main
    do_reset();
    drive(1, 3500, 0, 0, 0, 0); idle(1);
    expect_out("R2", 1, 0);
    feed(4, 4600); idle(1);
    expect_out("R5", 0, 0);
    idle(2);
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule